// File: doc/BRIEF.md
# Streaming 3x3 Neighbourhood Generator

This block sits in front of any 3x3 image operator (median, impulse-rejecting median, mean, edge detector). It takes a raster-ordered pixel stream, one pixel per accepted cycle, and for every pixel of the image delivers the full 3x3 neighbourhood centred on it. Each window is tagged with the row and column of its centre. Every pixel enters the block exactly once. Two line stores keep the two most recent rows, and a pair of column registers plus an output register assemble the window. No frame store is read back.

Borders are filled by replication and never by zeros. While the first row arrives, it is written into both line stores, so the row above the image repeats row 0. The first column of each line is duplicated into the left position. The last column is duplicated into the right position when the next line begins. After the last input line, the block runs one internal line of its own: it repeats the last row as the row below and completes the bottom border. Input is refused during that line. When no pixel is offered, nothing moves: no line store is written and no window is produced. A pixel flagged as start of frame always restarts the scan at row 0, column 0, and any partly received frame is abandoned.

Top module: `win3_stream`

## Requirements
- R1: In the cycle after reset is released, `win_valid` is 0 and `in_ready` is 1.
- R2: Exactly IMG_W*IMG_H windows are produced per frame, in raster order of their centres, with `ctr_row`/`ctr_col` naming the centre. The window centred on (r,c) with c<IMG_W-1 appears in the cycle after pixel (r+1,c+1) is accepted. The window for c=IMG_W-1 appears in the cycle after pixel (r+2,0) is accepted. Windows whose source rows lie beyond the input come from the internal bottom line.
- R3: Window element k=3*dy+dx (dy 0=upper row, dx 0=left column) sits at `win_pix[k*8 +: 8]` and holds pixel (r+dy-1, c+dx-1). The centre is k=4.
- R4: For centre row 0, the upper row of the window equals its middle row (top border repeats row 0).
- R5: For centre row IMG_H-1, the lower row equals the middle row. After the last pixel of a frame is accepted, `in_ready` is 0 for exactly IMG_W+1 cycles. During those cycles the remaining windows are produced without further input.
- R6: For centre column 0, the left column equals the middle column. For centre column IMG_W-1, the right column equals the middle column.
- R7: Cycles with `in_valid` low produce no window and leave `win_pix` unchanged. A stream with gaps yields the same windows as a gap-free one.
- R8: A pixel with `in_sof` high is taken as pixel (0,0) of a new frame, even in the middle of a frame. No window of the abandoned frame is produced afterwards.
- R9: Pixels offered with `in_sof` low while no frame is active are consumed and have no effect on any window. This includes the cycle in which `in_ready` returns after the bottom line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Pixel offered |
| in_sof | input | 1 | Offered pixel is the first of a frame |
| in_eol | input | 1 | Offered pixel is the last of its line |
| in_pix | input | 8 | Pixel value |
| in_ready | output | 1 | Block accepts a pixel this cycle |
| win_valid | output | 1 | Window output valid |
| win_pix | output | 72 | Nine window pixels, element k at bits k*8 +: 8 |
| ctr_row | output | $clog2(IMG_H) | Centre row of the window |
| ctr_col | output | $clog2(IMG_W) | Centre column of the window |

## Verification
The first pixel of a line does two jobs in the same cycle. It closes the previous line by emitting that line's right-border window, and it reseeds the column registers with its own value for the left border. The bench provokes this with lines sent back to back with no gap, and again in a stream with irregular gaps. The final cycle of the bottom line is a second meeting point, where bottom and right replication apply to one window together. A behavioural model computes the expected centre and all nine clamped pixels for every clock, and the bench compares coordinates and contents in every cycle.

// File: rtl/win3_pkg.sv
package win3_pkg;

    localparam int PIX_W = 8;

    typedef logic [PIX_W-1:0]   pix_t;
    typedef logic [9*PIX_W-1:0] win_t;

    // one vertical slice of the window: upper, middle and lower row
    typedef struct packed {
        pix_t top;
        pix_t mid;
        pix_t bot;
    } col_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_LIVE,
        PH_FLUSH,
        PH_TAIL
    } phase_e;

    function automatic col_t col_fill(input pix_t p);
        col_t c;
        c.top = p;
        c.mid = p;
        c.bot = p;
        return c;
    endfunction

    // element k = 3*row + column, element 0 in the least significant byte
    function automatic win_t win_pack(input col_t l, input col_t m, input col_t r);
        return {r.bot, m.bot, l.bot, r.mid, m.mid, l.mid, r.top, m.top, l.top};
    endfunction

    function automatic col_t win_col(input win_t w, input int cx);
        col_t c;
        c.top = w[cx*PIX_W +: PIX_W];
        c.mid = w[(3+cx)*PIX_W +: PIX_W];
        c.bot = w[(6+cx)*PIX_W +: PIX_W];
        return c;
    endfunction

endpackage

// File: rtl/win3_scan.sv
module win3_scan import win3_pkg::*; #(
    parameter int IMG_W = 128,
    parameter int IMG_H = 128,
    localparam int CW = $clog2(IMG_W),
    localparam int SW = $clog2(IMG_H + 2)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic          in_sof,
    input  logic          in_eol,
    output logic          in_ready,
    output logic          step,
    output logic          flushing,
    output logic          tail,
    output logic [SW-1:0] cur_row,
    output logic [CW-1:0] cur_col
);

    phase_e        phase_q;
    logic [SW-1:0] row_q;
    logic [CW-1:0] col_q;
    logic          take, restart, line_end, last_row;

    always_comb begin
        in_ready = (phase_q == PH_IDLE) || (phase_q == PH_LIVE);
        take     = in_valid && in_ready && (in_sof || (phase_q == PH_LIVE));
        restart  = take && in_sof;
        flushing = (phase_q == PH_FLUSH);
        tail     = (phase_q == PH_TAIL);
        step     = take || flushing || tail;
        cur_row  = restart ? '0 : row_q;
        cur_col  = restart ? '0 : col_q;
        line_end = (cur_col == CW'(IMG_W - 1)) || (take && in_eol);
        last_row = (cur_row == SW'(IMG_H - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            row_q   <= '0;
            col_q   <= '0;
        end else if (step) begin
            if (take) begin
                if (line_end) begin
                    col_q <= '0;
                    if (last_row) begin
                        phase_q <= PH_FLUSH;
                        row_q   <= SW'(IMG_H);
                    end else begin
                        phase_q <= PH_LIVE;
                        row_q   <= cur_row + SW'(1);
                    end
                end else begin
                    phase_q <= PH_LIVE;
                    row_q   <= cur_row;
                    col_q   <= cur_col + CW'(1);
                end
            end else if (flushing) begin
                if (line_end) begin
                    phase_q <= PH_TAIL;
                    row_q   <= SW'(IMG_H + 1);
                    col_q   <= '0;
                end else begin
                    col_q <= col_q + CW'(1);
                end
            end else begin
                phase_q <= PH_IDLE;
                row_q   <= '0;
                col_q   <= '0;
            end
        end
    end

    // R5: while input is refused, the bottom line advances every cycle
    p_flush_runs_r5: assert property (@(posedge clk) disable iff (rst)
        !in_ready |-> step);

    // R5: the closing cycle of the bottom line hands the input back
    p_tail_release_r5: assert property (@(posedge clk) disable iff (rst)
        tail |=> in_ready);

endmodule

// File: rtl/win3_rowbuf.sv
module win3_rowbuf import win3_pkg::*; #(
    parameter int IMG_W = 128,
    localparam int CW = $clog2(IMG_W)
) (
    input  logic          clk,
    input  logic          step,
    input  logic          first_row,
    input  logic          flushing,
    input  logic          tail,
    input  logic [CW-1:0] col,
    input  pix_t          pix,
    output col_t          colv
);

    localparam int STAGES = 2;

    pix_t rd [STAGES];
    pix_t wr [STAGES];
    logic wr_en;

    assign wr_en = step && !flushing && !tail;

    // stage 0 holds the row above the incoming one, stage 1 the row above that;
    // on the first row every stage is primed with the incoming pixel
    always_comb begin
        wr[0] = pix;
        for (int s = 1; s < STAGES; s++) begin
            wr[s] = first_row ? pix : rd[s-1];
        end
    end

    for (genvar s = 0; s < STAGES; s++) begin : g_line
        pix_t mem [IMG_W];
        assign rd[s] = mem[col];
        always_ff @(posedge clk) begin
            if (wr_en) begin
                mem[col] <= wr[s];
            end
        end
    end

    always_comb begin
        if (first_row) begin
            colv = col_fill(pix);
        end else begin
            colv.top = rd[1];
            colv.mid = rd[0];
            colv.bot = flushing ? rd[0] : pix;
        end
    end

endmodule

// File: rtl/win3_array.sv
module win3_array import win3_pkg::*; #(
    parameter int IMG_W = 128,
    parameter int IMG_H = 128,
    localparam int CW = $clog2(IMG_W),
    localparam int RW = $clog2(IMG_H),
    localparam int SW = $clog2(IMG_H + 2)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    input  logic [SW-1:0] cur_row,
    input  logic [CW-1:0] cur_col,
    input  col_t          colv,
    output logic          win_valid,
    output win_t          win_pix,
    output logic [RW-1:0] ctr_row,
    output logic [CW-1:0] ctr_col
);

    col_t          c_old, c_new;
    logic [CW-1:0] last_col;
    logic          line_start, emit;
    win_t          nxt;
    logic [SW-1:0] erow;
    logic [CW-1:0] ecol;

    always_comb begin
        line_start = (cur_col == '0);
        if (line_start) begin
            // close the previous line: repeat its last column on the right
            emit = (cur_row >= SW'(2));
            nxt  = win_pack(c_old, c_new, c_new);
            erow = cur_row - SW'(2);
            ecol = last_col;
        end else begin
            emit = (cur_row >= SW'(1));
            nxt  = win_pack(c_old, c_new, colv);
            erow = cur_row - SW'(1);
            ecol = cur_col - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            win_valid <= 1'b0;
            win_pix   <= '0;
            ctr_row   <= '0;
            ctr_col   <= '0;
        end else begin
            win_valid <= step && emit;
            if (step && emit) begin
                win_pix <= nxt;
                ctr_row <= erow[RW-1:0];
                ctr_col <= ecol;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (step) begin
            last_col <= cur_col;
            c_new    <= colv;
            c_old    <= line_start ? colv : c_new;
        end
    end

    p_coord_range_r2: assert property (@(posedge clk) disable iff (rst)
        win_valid |-> (32'(ctr_row) < IMG_H) && (32'(ctr_col) < IMG_W));

    p_top_edge_r4: assert property (@(posedge clk) disable iff (rst)
        (win_valid && ctr_row == '0) |->
            win_pix[3*PIX_W-1:0] == win_pix[6*PIX_W-1:3*PIX_W]);

    p_bottom_edge_r5: assert property (@(posedge clk) disable iff (rst)
        (win_valid && ctr_row == RW'(IMG_H - 1)) |->
            win_pix[9*PIX_W-1:6*PIX_W] == win_pix[6*PIX_W-1:3*PIX_W]);

    p_left_edge_r6: assert property (@(posedge clk) disable iff (rst)
        (win_valid && ctr_col == '0) |-> win_col(win_pix, 0) == win_col(win_pix, 1));

    p_right_edge_r6: assert property (@(posedge clk) disable iff (rst)
        (win_valid && ctr_col == CW'(IMG_W - 1)) |-> win_col(win_pix, 2) == win_col(win_pix, 1));

    p_stall_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        !step |=> !win_valid && $stable(win_pix));

endmodule

// File: rtl/win3_stream.sv
module win3_stream import win3_pkg::*; #(
    parameter int IMG_W = 128,
    parameter int IMG_H = 128,
    localparam int CW = $clog2(IMG_W),
    localparam int RW = $clog2(IMG_H),
    localparam int SW = $clog2(IMG_H + 2)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic               in_sof,
    input  logic               in_eol,
    input  logic [PIX_W-1:0]   in_pix,
    output logic               in_ready,
    output logic               win_valid,
    output logic [9*PIX_W-1:0] win_pix,
    output logic [RW-1:0]      ctr_row,
    output logic [CW-1:0]      ctr_col
);

    logic          step, flushing, tail;
    logic [SW-1:0] cur_row;
    logic [CW-1:0] cur_col;
    col_t          colv;

    win3_scan #(.IMG_W(IMG_W), .IMG_H(IMG_H)) u_scan (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_sof   (in_sof),
        .in_eol   (in_eol),
        .in_ready (in_ready),
        .step     (step),
        .flushing (flushing),
        .tail     (tail),
        .cur_row  (cur_row),
        .cur_col  (cur_col)
    );

    win3_rowbuf #(.IMG_W(IMG_W)) u_rows (
        .clk       (clk),
        .step      (step),
        .first_row (cur_row == '0),
        .flushing  (flushing),
        .tail      (tail),
        .col       (cur_col),
        .pix       (in_pix),
        .colv      (colv)
    );

    win3_array #(.IMG_W(IMG_W), .IMG_H(IMG_H)) u_win (
        .clk       (clk),
        .rst       (rst),
        .step      (step),
        .cur_row   (cur_row),
        .cur_col   (cur_col),
        .colv      (colv),
        .win_valid (win_valid),
        .win_pix   (win_pix),
        .ctr_row   (ctr_row),
        .ctr_col   (ctr_col)
    );

endmodule

// File: tb/win3_stream_test.sv
`timescale 1ns/1ps
module win3_stream_test;

    localparam int TW = 6;
    localparam int TH = 5;
    localparam int PW = win3_pkg::PIX_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic              in_sof = 1'b0;
    logic              in_eol = 1'b0;
    logic [PW-1:0]     in_pix = '0;
    logic              in_ready;
    logic              win_valid;
    logic [9*PW-1:0]   win_pix;
    logic [$clog2(TH)-1:0] ctr_row;
    logic [$clog2(TW)-1:0] ctr_col;

    win3_stream #(.IMG_W(TW), .IMG_H(TH)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof),
        .in_eol(in_eol), .in_pix(in_pix), .in_ready(in_ready),
        .win_valid(win_valid), .win_pix(win_pix),
        .ctr_row(ctr_row), .ctr_col(ctr_col)
    );

    always #4 clk = ~clk;

    int    n_chk = 0;
    int    n_err = 0;
    int    win_cnt = 0;
    string scen = "reset";
    int    img [TH][TW];

    // behavioural reference state
    int mph = 0, mr = 0, mc = 0;
    bit m_ready = 1'b1;
    bit exp_v = 1'b0;
    int exp_r, exp_c;
    int exp_p [9];

    task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s (%s) %s: actual %0d expected %0d at %0t", req, scen, what, act, expv, $time);
        end
    endtask

    function automatic int clampi(input int v, input int hi);
        if (v < 0) return 0;
        if (v > hi) return hi;
        return v;
    endfunction

    task automatic expect_win(input int r, input int c);
        exp_v = 1'b1;
        exp_r = r;
        exp_c = c;
        for (int k = 0; k < 9; k++) begin
            exp_p[k] = img[clampi(r + k/3 - 1, TH-1)][clampi(c + k%3 - 1, TW-1)];
        end
    endtask

    task automatic emit_rule(input int r, input int c);
        if (c > 0 && r >= 1) expect_win(r-1, c-1);
        else if (c == 0 && r >= 2) expect_win(r-2, TW-1);
    endtask

    // reference model: decides at each edge what the next cycle must show
    always @(posedge clk) begin
        exp_v = 1'b0;
        if (rst) begin
            mph = 0; mr = 0; mc = 0;
        end else begin
            case (mph)
                0, 1: if (in_valid && (in_sof || mph == 1)) begin
                    int r, c;
                    r = in_sof ? 0 : mr;
                    c = in_sof ? 0 : mc;
                    emit_rule(r, c);
                    if (c == TW-1) begin
                        mc = 0;
                        if (r == TH-1) begin mph = 2; mr = TH; end
                        else begin mph = 1; mr = r + 1; end
                    end else begin
                        mc = c + 1; mr = r; mph = 1;
                    end
                end
                2: begin
                    emit_rule(TH, mc);
                    if (mc == TW-1) begin mph = 3; mc = 0; end
                    else mc = mc + 1;
                end
                default: begin
                    expect_win(TH-1, TW-1);
                    mph = 0; mr = 0; mc = 0;
                end
            endcase
        end
        m_ready = (mph < 2);
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            chk(in_ready == m_ready, m_ready ? "R9" : "R5", "in_ready", int'(in_ready), int'(m_ready));
            chk(win_valid == exp_v, "R2", "win_valid", int'(win_valid), int'(exp_v));
            if (win_valid) win_cnt++;
            if (win_valid && exp_v) begin
                string tag;
                tag = (exp_r == 0) ? "R4" : (exp_r == TH-1) ? "R5" :
                      (exp_c == 0 || exp_c == TW-1) ? "R6" : "R3";
                chk(int'(ctr_row) == exp_r, "R2", "ctr_row", int'(ctr_row), exp_r);
                chk(int'(ctr_col) == exp_c, "R2", "ctr_col", int'(ctr_col), exp_c);
                for (int k = 0; k < 9; k++) begin
                    chk(int'(win_pix[k*PW +: PW]) == exp_p[k], tag, $sformatf("element %0d", k),
                        int'(win_pix[k*PW +: PW]), exp_p[k]);
                end
            end
        end
    end

    task automatic drive(input bit v, input bit sof, input bit eol, input int pix);
        @(negedge clk);
        in_valid = v;
        in_sof   = sof;
        in_eol   = eol;
        in_pix   = PW'(pix);
    endtask

    function automatic int pat(input int seed, input int r, input int c);
        if ((r + c + seed) % 5 == 0) return 0;
        if ((r * 3 + c + seed) % 7 == 0) return 255;
        return ((r * 37 + c * 11 + seed * 53) ^ (r * c)) & 255;
    endfunction

    // sends a frame (or its first 'limit' pixels); gaps inserts idle cycles
    task automatic send_frame(input int seed, input bit gaps, input int limit);
        @(posedge clk);
        #1;
        for (int r = 0; r < TH; r++)
            for (int c = 0; c < TW; c++)
                img[r][c] = (seed < 0) ? (r * 40 + c * 7) : pat(seed, r, c);
        win_cnt = 0;
        for (int idx = 0; idx < TH*TW && idx < limit; idx++) begin
            int r, c;
            r = idx / TW;
            c = idx % TW;
            if (gaps && ((idx * 5 + seed) % 3 == 0)) begin
                for (int g = 0; g <= idx % 3; g++) drive(1'b0, 1'b0, 1'b0, 255);
            end
            drive(1'b1, idx == 0, c == TW-1, img[r][c]);
        end
        if (limit >= TH*TW) begin
            // R5/R9: keep offering a stray pixel through the bottom line
            drive(1'b1, 1'b0, 1'b0, 0);
            @(negedge clk);
            while (!in_ready) @(negedge clk);
            in_valid = 1'b0;
        end else begin
            drive(1'b0, 1'b0, 1'b0, 0);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, 1'b0, 1'b0, 0);
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: state right after reset
        chk(win_valid == 1'b0, "R1", "win_valid after reset", int'(win_valid), 0);
        chk(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);

        scen = "R9 stray pixels before any frame";
        for (int i = 0; i < 5; i++) drive(1'b1, 1'b0, i == 2, 255 - i);
        idle(3);

        scen = "R3 back-to-back lines";
        send_frame(1, 1'b0, TH*TW);
        idle(3);
        chk(win_cnt == TH*TW, "R2", "windows per frame", win_cnt, TH*TW);

        scen = "R7 gapped stream";
        send_frame(2, 1'b1, TH*TW);
        idle(3);
        chk(win_cnt == TH*TW, "R7", "windows per gapped frame", win_cnt, TH*TW);

        scen = "R8 abandoned frame";
        send_frame(3, 1'b0, 2*TW + 3);
        scen = "R8 restart after abandon";
        send_frame(4, 1'b0, TH*TW);
        idle(3);
        chk(win_cnt == TH*TW, "R8", "windows after restart", win_cnt, TH*TW);

        scen = "R6 ramp image";
        send_frame(-1, 1'b1, TH*TW);
        idle(2);
        chk(win_cnt == TH*TW, "R6", "windows for ramp frame", win_cnt, TH*TW);

        scen = "R8 back-to-back frames";
        send_frame(5, 1'b0, TH*TW);
        send_frame(6, 1'b0, TH*TW);
        idle(3);
        chk(win_cnt == TH*TW, "R2", "windows in second of paired frames", win_cnt, TH*TW);

        finish_run();
    end

endmodule